// File: doc/BRIEF.md
# IO Translation Cache Range Invalidator

This block holds a small fully-associative cache of IO address translations and a range-invalidation engine driven by a single 64-bit command register. Each cached translation is tagged by the physical address of the page-table entry it came from, in units of 8-byte entries (address bits 41:3). A fill port installs translations and a lookup port reports whether a given entry address is cached and what data it holds.

To invalidate, software writes the command register with an entry count, the address of the first page-table entry and the busy bit set. The engine then visits one cache slot per clock and drops every valid slot whose tag lies inside the commanded range. When the last slot has been visited, busy clears by itself, and software polls the same register until it reads busy as 0 before issuing the next command. One command covers at most 2048 entries; longer ranges are split by software into several commands.

Top module: `iotc_inval`

## Requirements
- R1: After reset busy reads 0, the command register reads all zeros and no lookup hits.
- R2: The command register lives at offset 0x908 of a 13-bit (0x2000-byte) register space; reads at any other offset return 0 and writes there change nothing.
- R3: Command word layout: entry count in bits 63:53, first entry address in bits 41:3, busy in bit 0. A read at 0x908 returns the stored count and address in those positions, the live busy state in bit 0, and 0 in every other bit.
- R4: A write at 0x908 while idle stores the count and address; if bit 0 of the written word is 1 busy reads 1 for exactly NUM_ENTRIES clock cycles and then 0, while a write with bit 0 equal to 0 starts nothing.
- R5: An invalidation clears every valid slot whose tag t satisfies start <= t <= start + n - 1, where n is the entry count, and keeps every other slot.
- R6: An entry count field of 0 means 2048 entries.
- R7: A write at 0x908 while busy is 1 is ignored: the stored command and the operation in flight are unchanged.
- R8: A fill with a tag already cached replaces that slot's data; otherwise it takes the lowest-numbered free slot, or, if none is free, a slot chosen round-robin starting at slot 0. Fills presented while busy are ignored.
- R9: Lookup is combinational: lookup hit is 1 exactly when a valid slot has the presented tag, and lookup data then returns that slot's data.
- R10: The range end is computed without wrap-around: a range that runs past the largest tag does not reach small tags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 13 | Register byte offset for reads and writes |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for reg_addr_i |
| fill_valid_i | input | 1 | Install a translation |
| fill_tag_i | input | 39 | Entry address (bits 41:3) of the translation being installed |
| fill_data_i | input | DATA_W | Translation data to install |
| lkup_tag_i | input | 39 | Entry address to look up |
| lkup_hit_o | output | 1 | Lookup found a valid slot |
| lkup_data_o | output | DATA_W | Data of the hitting slot, 0 on a miss |

## Verification
On every cycle the assertions check that busy only rises after an accepted start write, that it stays high for exactly NUM_ENTRIES cycles, that the stored command holds still while a write arrives during busy, that no slot becomes valid while busy, and that at most one slot ever matches a lookup. Which slots survive a given range, the meaning of a zero count, the readback layout, the non-wrapping end of the range and the fill replacement order only show through the bench's scenarios, which fill known tags, run commands and probe the lookup port afterwards.

// File: rtl/iotc_pkg.sv
`timescale 1ns/1ps
package iotc_pkg;
  localparam int REG_AW     = 13;
  localparam logic [REG_AW-1:0] CMD_OFFSET = 13'h908;
  localparam int CNT_W      = 11;
  localparam int CNT_LSB    = 53;
  localparam int TAG_W      = 39;
  localparam int TAG_LSB    = 3;
  localparam int MAX_PER_CMD = 1 << CNT_W;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [TAG_W-1:0] start;
  } inv_cmd_t;
endpackage

// File: rtl/iotc_cmd_reg.sv
`timescale 1ns/1ps
module iotc_cmd_reg
  import iotc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  input  logic              busy_i,
  output logic              start_o,
  output inv_cmd_t          cmd_o
);
  inv_cmd_t cmd_q;
  logic     sel_wr, accept;
  logic     unused_bits;

  assign sel_wr  = reg_we_i && (reg_addr_i == CMD_OFFSET);
  assign accept  = sel_wr && !busy_i;
  assign start_o = accept && reg_wdata_i[0];
  assign unused_bits = ^{reg_wdata_i[CNT_LSB-1:TAG_LSB+TAG_W], reg_wdata_i[TAG_LSB-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (accept) begin
      cmd_q.cnt   <= reg_wdata_i[CNT_LSB +: CNT_W];
      cmd_q.start <= reg_wdata_i[TAG_LSB +: TAG_W];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == CMD_OFFSET) begin
      reg_rdata_o[CNT_LSB +: CNT_W] = cmd_q.cnt;
      reg_rdata_o[TAG_LSB +: TAG_W] = cmd_q.start;
      reg_rdata_o[0]                = busy_i;
    end
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/iotc_scan.sv
`timescale 1ns/1ps
module iotc_scan
  import iotc_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  inv_cmd_t         cmd_i,
  input  logic             ent_valid_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             kill_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);
  localparam int WIDE_W = TAG_W + 1;

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W:0]   span;
  logic [WIDE_W-1:0] lo, hi, tag_w;
  logic             in_range;

  // count 0 encodes the full 2048-entry span
  assign span  = (cmd_i.cnt == '0) ? (CNT_W+1)'(MAX_PER_CMD) : {1'b0, cmd_i.cnt};
  assign lo    = {1'b0, cmd_i.start};
  assign hi    = lo + WIDE_W'(span) - WIDE_W'(1);
  assign tag_w = {1'b0, ent_tag_i};
  assign in_range = (tag_w >= lo) && (tag_w <= hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign kill_o = busy_q && ent_valid_i && in_range;
endmodule

// File: rtl/iotc_store.sv
`timescale 1ns/1ps
module iotc_store
  import iotc_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fill_en_i,
  input  logic [TAG_W-1:0]       fill_tag_i,
  input  logic [DATA_W-1:0]      fill_data_i,
  input  logic                   kill_i,
  input  logic [IDX_W-1:0]       scan_idx_i,
  output logic                   scan_valid_o,
  output logic [TAG_W-1:0]       scan_tag_o,
  input  logic [TAG_W-1:0]       lkup_tag_i,
  output logic                   lkup_hit_o,
  output logic [DATA_W-1:0]      lkup_data_o,
  output logic [NUM_ENTRIES-1:0] valid_o,
  output logic [NUM_ENTRIES-1:0] hit_vec_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  logic [NUM_ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]       tag_q  [NUM_ENTRIES];
  logic [DATA_W-1:0]      data_q [NUM_ENTRIES];
  logic [IDX_W-1:0]       victim_q;
  logic [NUM_ENTRIES-1:0] fill_match;
  logic [IDX_W-1:0]       tgt;
  logic                   use_victim;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign fill_match[g] = valid_q[g] && (tag_q[g] == fill_tag_i);
    assign hit_vec_o[g]  = valid_q[g] && (tag_q[g] == lkup_tag_i);
  end

  // target: matching slot, else lowest free slot, else victim pointer
  always_comb begin
    tgt        = victim_q;
    use_victim = 1'b1;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        tgt        = IDX_W'(i);
        use_victim = 1'b0;
      end
    end
    if (|fill_match) begin
      use_victim = 1'b0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (fill_match[i]) tgt = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      victim_q <= '0;
    end else begin
      if (fill_en_i) begin
        valid_q[tgt] <= 1'b1;
        if (use_victim) victim_q <= (victim_q == LAST) ? '0 : victim_q + IDX_W'(1);
      end
      if (kill_i) valid_q[scan_idx_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      tag_q[tgt]  <= fill_tag_i;
      data_q[tgt] <= fill_data_i;
    end
  end

  always_comb begin
    lkup_data_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hit_vec_o[i]) lkup_data_o = lkup_data_o | data_q[i];
    end
  end

  assign lkup_hit_o   = |hit_vec_o;
  assign scan_valid_o = valid_q[scan_idx_i];
  assign scan_tag_o   = tag_q[scan_idx_i];
  assign valid_o      = valid_q;
endmodule

// File: rtl/iotc_inval.sv
`timescale 1ns/1ps
module iotc_inval
  import iotc_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int DATA_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [12:0]       reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  input  logic              fill_valid_i,
  input  logic [38:0]       fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic [38:0]       lkup_tag_i,
  output logic              lkup_hit_o,
  output logic [DATA_W-1:0] lkup_data_o
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  inv_cmd_t               cmd_q;
  logic                   busy, start, kill, scan_valid;
  logic [IDX_W-1:0]       scan_idx;
  logic [TAG_W-1:0]       scan_tag;
  logic [NUM_ENTRIES-1:0] valid_vec, hit_vec;

  iotc_cmd_reg u_reg (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .start_o(start), .cmd_o(cmd_q)
  );

  iotc_scan #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_scan (
    .clk_i, .rst_ni, .start_i(start), .cmd_i(cmd_q),
    .ent_valid_i(scan_valid), .ent_tag_i(scan_tag),
    .busy_o(busy), .idx_o(scan_idx), .kill_o(kill)
  );

  iotc_store #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni,
    .fill_en_i(fill_valid_i && !busy), .fill_tag_i, .fill_data_i,
    .kill_i(kill), .scan_idx_i(scan_idx),
    .scan_valid_o(scan_valid), .scan_tag_o(scan_tag),
    .lkup_tag_i, .lkup_hit_o, .lkup_data_o,
    .valid_o(valid_vec), .hit_vec_o(hit_vec)
  );
endmodule

// File: rtl/iotc_chk.sv
`timescale 1ns/1ps
module iotc_chk
  import iotc_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   busy_i,
  input logic                   reg_we_i,
  input logic [12:0]            reg_addr_i,
  input logic [63:0]            reg_wdata_i,
  input inv_cmd_t               cmd_i,
  input logic [NUM_ENTRIES-1:0] valid_i,
  input logic [NUM_ENTRIES-1:0] hit_vec_i
);
  localparam int CW = $clog2(NUM_ENTRIES + 1) + 1;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_i) busy_cnt <= busy_cnt + CW'(1);
    else             busy_cnt <= '0;
  end

  assert_start_by_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(reg_we_i && reg_addr_i == CMD_OFFSET && reg_wdata_i[0]));

  assert_busy_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> busy_cnt < CW'(NUM_ENTRIES));

  assert_busy_ends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && busy_cnt == CW'(NUM_ENTRIES - 1)) |=> !busy_i);

  assert_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && reg_we_i) |=> $stable(cmd_i));

  assert_no_fill_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($countones(valid_i) <= $countones($past(valid_i))));

  assert_single_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_i));
endmodule

bind iotc_inval iotc_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .cmd_i(cmd_q),
  .valid_i(valid_vec), .hit_vec_i(hit_vec)
);

// File: tb/iotc_inval_test.sv
`timescale 1ns/1ps
module iotc_inval_test;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam logic [12:0] CMD = 13'h908;
  localparam logic [38:0] TMAX = {39{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [12:0]   reg_addr = CMD;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;
  logic          fill_v = 1'b0;
  logic [38:0]   fill_tag = '0;
  logic [DW-1:0] fill_data = '0;
  logic [38:0]   lkup_tag = '0;
  logic          lkup_hit;
  logic [DW-1:0] lkup_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iotc_inval #(.NUM_ENTRIES(N), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .fill_valid_i(fill_v),
    .fill_tag_i(fill_tag), .fill_data_i(fill_data), .lkup_tag_i(lkup_tag),
    .lkup_hit_o(lkup_hit), .lkup_data_o(lkup_data)
  );

  typedef struct {
    logic [38:0]   tag;
    logic          hit;
    logic [DW-1:0] data;
    string         req;
  } probe_t;

  probe_t exp_q[$];
  event   probe_ev;

  function automatic logic [63:0] mk(logic [10:0] cnt, logic [38:0] st, logic go);
    return {cnt, 11'b0, st, 2'b0, go};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(probe_ev);
      #0.5;
      if (exp_q.size() > 0) begin
        probe_t p;
        p = exp_q.pop_front();
        n_chk++;
        if (lkup_hit !== p.hit || (p.hit && lkup_data !== p.data)) begin
          n_fail++;
          $display("FAIL %s: tag %0d actual hit=%b data=%h expected hit=%b data=%h",
                   p.req, p.tag, lkup_hit, lkup_data, p.hit, p.data);
        end
      end
    end
  end

  task automatic probe(logic [38:0] tag, logic hit, logic [DW-1:0] data, string req);
    probe_t p;
    @(negedge clk);
    lkup_tag = tag;
    p.tag = tag; p.hit = hit; p.data = data; p.req = req;
    exp_q.push_back(p);
    -> probe_ev;
    #1;
  endtask

  task automatic wr(logic [12:0] a, logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = CMD;
  endtask

  task automatic fill(logic [38:0] t, logic [DW-1:0] d);
    @(negedge clk);
    fill_v = 1'b1; fill_tag = t; fill_data = d;
    @(negedge clk);
    fill_v = 1'b0;
  endtask

  task automatic rd(logic [12:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
    reg_addr = CMD;
  endtask

  // counts cycles busy reads 1, starting at the negedge after the accepting edge
  task automatic wait_idle(output int cyc);
    cyc = 0;
    reg_addr = CMD;
    #0.5;
    while (reg_rdata[0] && cyc < 100) begin
      cyc++;
      @(negedge clk);
      #0.5;
    end
  endtask

  initial begin
    logic [63:0] r;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(CMD, r);
    check("R1 reset readback", r, 64'h0);
    probe(39'd0, 1'b0, '0, "R1 empty after reset");

    // R8 fills, R9 lookups
    for (int i = 0; i < N; i++) fill(39'(100 + i), DW'(32'hA000 + i));
    probe(39'd100, 1'b1, 32'hA000, "R9 hit slot0");
    probe(39'd107, 1'b1, 32'hA007, "R9 hit slot7");
    probe(39'd99, 1'b0, '0, "R9 miss");
    fill(39'd102, 32'hBEEF);
    probe(39'd102, 1'b1, 32'hBEEF, "R8 hit update");
    fill(39'd110, 32'hC110);  // full: round-robin victim slot0 (tag 100)
    probe(39'd100, 1'b0, '0, "R8 victim evicted");
    probe(39'd110, 1'b1, 32'hC110, "R8 victim replaced");
    probe(39'd101, 1'b1, 32'hA001, "R8 others kept");

    // R3 / R4 store without start
    wr(CMD, mk(11'd5, 39'd101, 1'b0));
    rd(CMD, r);
    check("R3 readback no start", r, mk(11'd5, 39'd101, 1'b0));
    probe(39'd101, 1'b1, 32'hA001, "R4 no start no invalidate");

    // R2 other offset
    wr(13'h910, mk(11'd7, 39'd55, 1'b1));
    rd(13'h910, r);
    check("R2 other offset reads 0", r, 64'h0);
    rd(CMD, r);
    check("R2 other offset write ignored", r, mk(11'd5, 39'd101, 1'b0));

    // R4 / R5 invalidate 101..102; reserved write bits dropped (R3)
    wr(CMD, mk(11'd2, 39'd101, 1'b1) | 64'h001F_F000_0000_0006);
    wait_idle(cyc);
    check("R4 busy cycles", 64'(cyc), 64'(N));
    rd(CMD, r);
    check("R3 readback after run", r, mk(11'd2, 39'd101, 1'b0));
    probe(39'd101, 1'b0, '0, "R5 start cleared");
    probe(39'd102, 1'b0, '0, "R5 end cleared");
    probe(39'd103, 1'b1, 32'hA003, "R5 past end kept");
    probe(39'd110, 1'b1, 32'hC110, "R5 outside kept");

    // R7 write while busy ignored
    wr(CMD, mk(11'd1, 39'd105, 1'b1));
    wr(CMD, mk(11'd4, 39'd103, 1'b1));
    wait_idle(cyc);
    rd(CMD, r);
    check("R7 command unchanged", r, mk(11'd1, 39'd105, 1'b0));
    probe(39'd105, 1'b0, '0, "R7 first command ran");
    probe(39'd103, 1'b1, 32'hA003, "R7 second command ignored");
    probe(39'd106, 1'b1, 32'hA006, "R7 second command ignored hi");

    // R8 fill while busy ignored
    wr(CMD, mk(11'd1, 39'd5000, 1'b1));
    fill(39'd300, 32'h0300);
    wait_idle(cyc);
    probe(39'd300, 1'b0, '0, "R8 fill during busy ignored");

    // R6 count 0 means 2048
    fill(39'd1000, 32'h1000);
    fill(39'd3047, 32'h3047);
    fill(39'd3048, 32'h3048);
    wr(CMD, mk(11'd0, 39'd1000, 1'b1));
    wait_idle(cyc);
    check("R6 busy cycles", 64'(cyc), 64'(N));
    probe(39'd1000, 1'b0, '0, "R6 first cleared");
    probe(39'd3047, 1'b0, '0, "R6 entry 2047 cleared");
    probe(39'd3048, 1'b1, 32'h3048, "R6 entry 2048 kept");

    // R10 no wrap
    fill(39'd0, 32'h0000_0F00);
    fill(TMAX, 32'hFFFF);
    wr(CMD, mk(11'd2, TMAX, 1'b1));
    wait_idle(cyc);
    probe(TMAX, 1'b0, '0, "R10 top cleared");
    probe(39'd0, 1'b1, 32'h0000_0F00, "R10 no wrap to zero");

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule